// File: doc/BRIEF.md
# Deferred-Retire Column Write Buffer

This block models the column-side write path of a memory device in which a write is committed in two phases. A framed write command aimed at this device queues its bank and column address, and a fixed number of packet slots later the data word on the write bus is captured into a one-entry holding buffer. The buffer is not written to storage straight away. It is retired into a small bank-by-column array by a later column slot, and a per-byte keep mask sampled in that same slot can protect selected bytes of the old word.

A controller uses the block by issuing one column command per packet slot. A slot carries a framing bit, an opcode, a device number, a bank and a column, together with a write-data word and a byte mask. Reads aimed at this device delay the retire, so a read that reaches the written address before the retire returns the stale word. A read issued after the retire returns the new word. Read data appears after a fixed pipeline latency with a one-cycle valid strobe. Commands for other devices never load or read, but any framed slot that is not a read to this device can still serve as a retire slot.

Top module: `deferred_retire_wbuf`

## Requirements
- R1: After reset the array holds all zeros, the buffer is empty and `rd_valid` is low.
- R2: A framed write to this device (opcode 2'b10, `col_dev` equal to `DEV_ID`) takes its data word from `wdata` in the slot exactly `T_CWD` slots after the command. Data on other slots is not used.
- R3: The buffered word is retired into the array at the slot `T_RTR` slots after the write command when that slot is framed and is not a read to this device. A later read returns the new word.
- R4: An unframed slot, or a framed read to this device (opcode 2'b01), does not retire. The retire then happens at the first later framed slot that is not a read to this device. Reads issued before that slot return the old word.
- R5: A framed slot addressed to another device, including a read, counts as a retire slot. Writes and reads to another device neither load the buffer nor raise `rd_valid`.
- R6: `msk_keep` bit i set to 1 keeps byte i (bits 8i+7..8i) of the old array word. The mask is taken only from the slot that performs the retire.
- R7: When a new write reaches its data slot while the buffer still holds an entry, the held entry is retired in that slot first and the new write is then loaded. Both words reach the array.
- R8: A read to this device raises `rd_valid` for one cycle with the word in `rd_data`, `T_CAC` rising edges after the command, counting the edge that samples it. No other cycle raises `rd_valid`.
- R9: A read to an address in the same slot as a forced retire to that address returns the word as it was before that retire.
- R10: Opcode 2'b11 and opcode 2'b00 perform no access. A framed slot carrying either one is a retire slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Packet-slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_frame | input | 1 | A column packet is present in this slot |
| col_op | input | 2 | Opcode: 00 none, 01 read, 10 write, 11 reserved |
| col_dev | input | DEV_W | Target device number |
| col_bank | input | clog2(BANKS) | Bank address |
| col_col | input | clog2(COLS) | Column address |
| wdata | input | 8*BYTES | Write-data word for this slot |
| msk_keep | input | BYTES | Per-byte keep mask for this slot |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 8*BYTES | Read data word |

## Verification
Two pairs of functions can fall in one slot. A forced retire of the held entry can coincide with the arrival of the next write's data. A read to the same address can coincide with that forced retire. The bench provokes both by blocking the first write with a read until a second write reaches its data slot, and by issuing another read to the first address in that same slot. It judges the results by requiring the coincident read to return the pre-retire word and the following read to return the first write's word. A further read checks that the second write lands as well after its own retire.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_READ  = 2'b01,
      OP_WRITE = 2'b10,
      OP_RSVD  = 2'b11
   } col_op_e;

   function automatic bool_is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dwb_decode.sv
module dwb_decode
   import dwb_pkg::*;
#(
   parameter int DEV_W  = 4,
   parameter int DEV_ID = 3
) (
   input  logic             col_frame,
   input  logic [1:0]       col_op,
   input  logic [DEV_W-1:0] col_dev,
   output logic             rd_me,
   output logic             wr_me,
   output logic             slot_ok
);

   localparam logic [DEV_W-1:0] MY_ID = DEV_W'(DEV_ID);

   if (DEV_ID < 0 || DEV_ID >= (1 << DEV_W)) begin : g_bad_id
      $error("dwb_decode: DEV_ID does not fit in DEV_W bits");
   end

   col_op_e op;
   logic    to_me;

   assign op      = col_op_e'(col_op);
   assign to_me   = col_frame && (col_dev == MY_ID);
   assign rd_me   = to_me && (op == OP_READ);
   assign wr_me   = to_me && (op == OP_WRITE);
   // any framed slot that is not a read aimed here may retire the buffer
   assign slot_ok = col_frame && !rd_me;

endmodule

// File: rtl/dwb_load_pipe.sv
module dwb_load_pipe #(
   parameter int ADDR_W = 5,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   output logic              pop_valid,
   output logic [ADDR_W-1:0] pop_addr
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("dwb_load_pipe: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0]  stg_v;
   logic [ADDR_W-1:0] stg_a [DEPTH];

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_v[0] <= 1'b0;
            stg_a[0] <= '0;
         end else begin
            stg_v[0] <= push;
            stg_a[0] <= push_addr;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_v <= '0;
            for (int i = 0; i < DEPTH; i++) stg_a[i] <= '0;
         end else begin
            stg_v <= {stg_v[DEPTH-2:0], push};
            stg_a[0] <= push_addr;
            for (int i = 1; i < DEPTH; i++) stg_a[i] <= stg_a[i-1];
         end
      end
   end

   assign pop_valid = stg_v[DEPTH-1];
   assign pop_addr  = stg_a[DEPTH-1];

endmodule

// File: rtl/dwb_wbuf.sv
module dwb_wbuf #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 64,
   parameter int HOLD   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   input  logic              slot_ok,
   output logic              buf_valid,
   output logic              ret_fire,
   output logic [ADDR_W-1:0] ret_addr,
   output logic [DATA_W-1:0] ret_data
);

   if (HOLD < 1) begin : g_bad_hold
      $error("dwb_wbuf: HOLD must be at least 1");
   end

   logic elig;

   if (HOLD == 1) begin : g_immediate
      // eligible from the first slot after loading
      assign elig = 1'b1;
   end else begin : g_countdown
      localparam int CNT_W = $clog2(HOLD);
      logic [CNT_W-1:0] wait_q;

      always_ff @(posedge clk) begin
         if (!rst_n)             wait_q <= '0;
         else if (load)          wait_q <= CNT_W'(HOLD - 1);
         else if (wait_q != '0)  wait_q <= wait_q - 1'b1;
      end

      assign elig = (wait_q == '0);
   end

   // a fresh load pushes the held entry out in the same slot
   assign ret_fire = buf_valid && (load || (elig && slot_ok));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_valid <= 1'b0;
         ret_addr  <= '0;
         ret_data  <= '0;
      end else if (load) begin
         buf_valid <= 1'b1;
         ret_addr  <= load_addr;
         ret_data  <= load_data;
      end else if (ret_fire) begin
         buf_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/dwb_array.sv
module dwb_array #(
   parameter int  BYTES  = 8,
   parameter int  DEPTH  = 32,
   parameter int  T_CAC  = 4,
   localparam int DATA_W = BYTES * 8,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BYTES-1:0]  wr_keep,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   if (T_CAC < 1) begin : g_bad_cac
      $error("dwb_array: T_CAC must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] merged;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign merged[b*8 +: 8] = wr_keep[b] ? mem[wr_addr][b*8 +: 8]
                                           : wr_data[b*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= merged;
      end
   end

   logic [T_CAC-1:0]  pv;
   logic [DATA_W-1:0] pd [T_CAC];

   if (T_CAC == 1) begin : g_cac_one
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pv[0] <= 1'b0;
            pd[0] <= '0;
         end else begin
            pv[0] <= rd_en;
            pd[0] <= rd_en ? mem[rd_addr] : '0;
         end
      end
   end else begin : g_cac_deep
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pv <= '0;
            for (int i = 0; i < T_CAC; i++) pd[i] <= '0;
         end else begin
            pv <= {pv[T_CAC-2:0], rd_en};
            pd[0] <= rd_en ? mem[rd_addr] : '0;
            for (int i = 1; i < T_CAC; i++) pd[i] <= pd[i-1];
         end
      end
   end

   assign rd_valid = pv[T_CAC-1];
   assign rd_data  = pd[T_CAC-1];

endmodule

// File: rtl/deferred_retire_wbuf.sv
module deferred_retire_wbuf
   import dwb_pkg::*;
#(
   parameter int  DEV_W  = 4,
   parameter int  DEV_ID = 3,
   parameter int  BANKS  = 4,
   parameter int  COLS   = 8,
   parameter int  BYTES  = 8,
   parameter int  T_CWD  = 2,
   parameter int  T_RTR  = 3,
   parameter int  T_CAC  = 4,
   localparam int BANK_W = $clog2(BANKS),
   localparam int COL_W  = $clog2(COLS),
   localparam int DATA_W = BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              col_frame,
   input  logic [1:0]        col_op,
   input  logic [DEV_W-1:0]  col_dev,
   input  logic [BANK_W-1:0] col_bank,
   input  logic [COL_W-1:0]  col_col,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BYTES-1:0]  msk_keep,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   localparam int ADDR_W = BANK_W + COL_W;
   localparam int DEPTH  = BANKS * COLS;
   localparam int HOLD   = T_RTR - T_CWD;

   if (!bool_is_pow2(BANKS) || !bool_is_pow2(COLS)) begin : g_bad_geom
      $error("deferred_retire_wbuf: BANKS and COLS must be powers of two, at least 2");
   end
   if (T_CWD < 1) begin : g_bad_cwd
      $error("deferred_retire_wbuf: T_CWD must be at least 1");
   end
   if (T_RTR <= T_CWD) begin : g_bad_rtr
      $error("deferred_retire_wbuf: T_RTR must exceed T_CWD");
   end
   if (BYTES < 1) begin : g_bad_bytes
      $error("deferred_retire_wbuf: BYTES must be at least 1");
   end

   logic              rd_me;
   logic              wr_me;
   logic              slot_ok;
   logic [ADDR_W-1:0] cmd_addr;
   logic              load_fire;
   logic [ADDR_W-1:0] load_addr;
   logic              buf_valid;
   logic              ret_fire;
   logic [ADDR_W-1:0] ret_addr;
   logic [DATA_W-1:0] ret_data;

   assign cmd_addr = {col_bank, col_col};

   dwb_decode #(
      .DEV_W  (DEV_W),
      .DEV_ID (DEV_ID)
   ) u_decode (
      .col_frame (col_frame),
      .col_op    (col_op),
      .col_dev   (col_dev),
      .rd_me     (rd_me),
      .wr_me     (wr_me),
      .slot_ok   (slot_ok)
   );

   dwb_load_pipe #(
      .ADDR_W (ADDR_W),
      .DEPTH  (T_CWD)
   ) u_load_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_me),
      .push_addr (cmd_addr),
      .pop_valid (load_fire),
      .pop_addr  (load_addr)
   );

   dwb_wbuf #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .HOLD   (HOLD)
   ) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_fire),
      .load_addr (load_addr),
      .load_data (wdata),
      .slot_ok   (slot_ok),
      .buf_valid (buf_valid),
      .ret_fire  (ret_fire),
      .ret_addr  (ret_addr),
      .ret_data  (ret_data)
   );

   dwb_array #(
      .BYTES (BYTES),
      .DEPTH (DEPTH),
      .T_CAC (T_CAC)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ret_fire),
      .wr_addr  (ret_addr),
      .wr_data  (ret_data),
      .wr_keep  (msk_keep),
      .rd_en    (rd_me),
      .rd_addr  (cmd_addr),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/dwb_checker.sv
module dwb_checker #(
   parameter int T_CAC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic col_frame,
   input logic rd_me,
   input logic load_fire,
   input logic buf_valid,
   input logic ret_fire,
   input logic rd_valid
);

   // independent record of issued reads, one bit per slot of latency
   logic [T_CAC-1:0] seen_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_rd <= '0;
      end else begin
         seen_rd[0] <= rd_me;
         for (int i = 1; i < T_CAC; i++) seen_rd[i] <= seen_rd[i-1];
      end
   end

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rd_valid);

   a_r2_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
      load_fire |=> buf_valid);

   a_r3_retire_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_fire && !load_fire) |=> !buf_valid);

   a_r4_read_blocks_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_fire && !load_fire) |-> (col_frame && !rd_me));

   a_r7_load_forces_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fire && buf_valid) |-> ret_fire);

   a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == seen_rd[T_CAC-1]);

endmodule

bind deferred_retire_wbuf dwb_checker #(
   .T_CAC (T_CAC)
) u_dwb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .col_frame (col_frame),
   .rd_me     (rd_me),
   .load_fire (load_fire),
   .buf_valid (buf_valid),
   .ret_fire  (ret_fire),
   .rd_valid  (rd_valid)
);

// File: tb/deferred_retire_wbuf_bench.sv
module deferred_retire_wbuf_bench;

   localparam int T_CWD = 2;
   localparam int T_RTR = 3;
   localparam int T_CAC = 4;
   localparam int ME    = 3;
   localparam int OTHER = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        col_frame = 1'b0;
   logic [1:0]  col_op = 2'b00;
   logic [3:0]  col_dev = '0;
   logic [1:0]  col_bank = '0;
   logic [2:0]  col_col = '0;
   logic [63:0] wdata = '0;
   logic [7:0]  msk_keep = '0;
   logic        rd_valid;
   logic [63:0] rd_data;

   always #2 clk = ~clk;

   deferred_retire_wbuf u_deferred_retire_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .col_frame (col_frame),
      .col_op    (col_op),
      .col_dev   (col_dev),
      .col_bank  (col_bank),
      .col_col   (col_col),
      .wdata     (wdata),
      .msk_keep  (msk_keep),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   int last_s = 0;
   int rd_issued = 0;
   bit done = 1'b0;
   int          obs_cyc [$];
   logic [63:0] obs_dat [$];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         obs_cyc.push_back(cyc);
         obs_dat.push_back(rd_data);
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put(input bit f, input logic [1:0] op, input int dev,
                      input int bank, input int col,
                      input logic [63:0] wd, input logic [7:0] keep);
      @(negedge clk);
      col_frame = f;
      col_op    = op;
      col_dev   = 4'(dev);
      col_bank  = 2'(bank);
      col_col   = 3'(col);
      wdata     = wd;
      msk_keep  = keep;
      last_s    = cyc + 1;
      if (f && op == 2'b01 && dev == ME) rd_issued++;
   endtask

   task automatic idle(input logic [63:0] wd = '0, input logic [7:0] keep = '0);
      put(1'b0, 2'b00, 0, 0, 0, wd, keep);
   endtask

   task automatic nop(input logic [7:0] keep = '0);
      put(1'b1, 2'b00, ME, 0, 0, '0, keep);
   endtask

   task automatic wr(input int dev, input int bank, input int col);
      put(1'b1, 2'b10, dev, bank, col, '0, '0);
   endtask

   task automatic rd(input int dev, input int bank, input int col,
                     input logic [63:0] wd = '0);
      put(1'b1, 2'b01, dev, bank, col, wd, '0);
   endtask

   task automatic flush();
      for (int i = 0; i < T_CAC + 3; i++) idle();
   endtask

   task automatic expect_read(input int s, input logic [63:0] exp, input string req);
      int          tgt;
      bit          found;
      logic [63:0] got;
      tgt   = s + T_CAC - 1;
      found = 1'b0;
      got   = 'x;
      foreach (obs_cyc[i]) begin
         if (obs_cyc[i] == tgt) begin
            found = 1'b1;
            got   = obs_dat[i];
         end
      end
      check(found && (got === exp), req, $sformatf("read issued in slot %0d", s), got, exp);
   endtask

   task automatic t_reset();
      int s;
      @(negedge clk);
      check(rd_valid === 1'b0, "R1", "rd_valid after reset", 64'(rd_valid), 64'h0);
      rd(ME, 0, 0); s = last_s;
      flush();
      expect_read(s, 64'h0, "R1");
   endtask

   task automatic t_basic();
      int s;
      bit early;
      wr(ME, 1, 2);
      idle(64'hDEAD_BEEF_DEAD_BEEF);       // not the data slot
      idle(64'h0123_4567_89AB_CDEF);       // data slot
      nop();                               // retire slot
      rd(ME, 1, 2); s = last_s;
      flush();
      expect_read(s, 64'h0123_4567_89AB_CDEF, "R2 R3");
      early = 1'b0;
      foreach (obs_cyc[i]) if (obs_cyc[i] == s + T_CAC - 2) early = 1'b1;
      check(!early, "R8", "no strobe one cycle early", 64'(early), 64'h0);
   endtask

   task automatic t_block();
      int s1, s2, s3;
      wr(ME, 2, 1);
      idle();
      idle(64'h2222_0000_2222_0000);
      rd(ME, 2, 1); s1 = last_s;           // read to self blocks
      idle();                              // unframed blocks
      rd(ME, 2, 1); s2 = last_s;
      nop();                               // first eligible slot
      rd(ME, 2, 1); s3 = last_s;
      flush();
      expect_read(s1, 64'h0, "R4");
      expect_read(s2, 64'h0, "R4");
      expect_read(s3, 64'h2222_0000_2222_0000, "R4");
   endtask

   task automatic t_other_dev();
      int s1, s2, s3;
      wr(ME, 3, 4);
      idle();
      idle(64'h3333_3333_0000_0003);
      rd(ME, 3, 4); s1 = last_s;
      rd(OTHER, 3, 4);                     // foreign read retires
      rd(ME, 3, 4); s2 = last_s;
      wr(OTHER, 3, 5);
      idle();
      idle(64'h4444_4444_4444_4444);
      nop();
      rd(ME, 3, 5); s3 = last_s;
      flush();
      expect_read(s1, 64'h0, "R5");
      expect_read(s2, 64'h3333_3333_0000_0003, "R5");
      expect_read(s3, 64'h0, "R5");
   endtask

   task automatic t_reserved();
      int s;
      wr(ME, 0, 6);
      idle();
      idle(64'h5555_AAAA_5555_AAAA);
      idle();
      put(1'b1, 2'b11, ME, 0, 6, '0, '0);   // reserved opcode retires
      rd(ME, 0, 6); s = last_s;
      flush();
      expect_read(s, 64'h5555_AAAA_5555_AAAA, "R10");
   endtask

   task automatic t_mask();
      int s;
      wr(ME, 1, 7);
      idle();
      idle(64'h1111_1111_1111_1111);
      nop();
      wr(ME, 1, 7);
      idle();
      idle(64'hAAAA_AAAA_AAAA_AAAA, 8'hFF); // mask here must not count
      nop(8'h0F);                           // keep low four bytes
      rd(ME, 1, 7); s = last_s;
      flush();
      expect_read(s, 64'hAAAA_AAAA_1111_1111, "R6");
   endtask

   task automatic t_forced();
      int s1, s2, s3, s4;
      wr(ME, 2, 3);                         // write G
      idle();
      put(1'b1, 2'b10, ME, 2, 4, 64'h6666_0000_0000_6666, '0); // write H, data of G
      rd(ME, 2, 3); s1 = last_s;            // blocks G
      rd(ME, 2, 3, 64'h7777_7777_7777_0000); s2 = last_s; // H loads, G forced out
      rd(ME, 2, 3); s3 = last_s;
      idle();
      nop();                                // H retires
      rd(ME, 2, 4); s4 = last_s;
      flush();
      expect_read(s1, 64'h0, "R4");
      expect_read(s2, 64'h0, "R9");
      expect_read(s3, 64'h6666_0000_0000_6666, "R7");
      expect_read(s4, 64'h7777_7777_7777_0000, "R7");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_block();
      t_other_dev();
      t_reserved();
      t_mask();
      t_forced();
      check(obs_cyc.size() == rd_issued, "R8", "strobe count",
            64'(obs_cyc.size()), 64'(rd_issued));
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected 0 hung cycles", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule